// File: doc/BRIEF.md
# Register-Operand ALU with Shifter and Multiply-Accumulate

This block runs register-to-register data-processing instructions. A 32-bit instruction word arrives together with up to three register values and the current condition flags. The block then produces a result, a write-enable for the destination register and the updated flags. The second operand passes through a barrel shifter. Logic operations can invert that operand after the shift. A multiply form reuses the same fields to compute an accumulator plus or minus a product. Each instruction runs at either 64-bit or 32-bit width.

The register file supplies the three source values. The block decides which of them are real and which read as the hard-wired zero register. Every instruction, whatever its kind, takes a fixed `LAT` cycles. Instructions may be issued back to back, and each one returns a single `done` strobe in issue order.

Top module: `regalu_core`

## Requirements
- R1: Instruction fields are decoded as follows.
  - Bit 31 selects 64-bit (1) or 32-bit (0) width.
  - Bit 28 set selects the multiply form.
  - Otherwise, bit 24 selects arithmetic (1) or logic (0).
  - Bits 30:29 hold the opcode.
  - The destination is in bits 4:0. The sources are in bits 9:5 (first operand) and 20:16 (second operand).
  - Bits 27:25 are ignored.
- R2: Bits 23:22 choose the shift applied to the second operand: 0 = LSL, 1 = LSR, 2 = ASR, 3 = ROR. The amount is in bits 15:10 and is taken modulo the active width.
- R3: In 32-bit mode only the low 32 bits of each source are used. ASR treats the operand as a signed 32-bit value. The result's upper 32 bits are zero, and N is taken from bit 31.
- R4: Arithmetic opcodes are 0 = ADD, 1 = ADDS, 2 = SUB and 3 = SUBS. The flags bus is {N,Z,C,V}, with N in bit 3. ADDS sets N, Z, C (unsigned carry out) and V (signed overflow).
- R5: SUBS sets C when the first operand is at least the second, compared as unsigned values. It sets V when the two operand signs differ and the result sign differs from the first operand.
- R6: Logic opcodes are 0 = AND, 1 = OR, 2 = XOR and 3 = flag-setting AND.
  - Bit 21 set inverts the shifted second operand before the operation.
  - The flag-setting AND sets N and Z and clears C and V.
- R7: Some encodings are illegal:
  - an arithmetic operation with ROR;
  - an arithmetic operation with bit 21 set;
  - a multiply that lacks opcode 0, bit 24 = 1, shift 0 and bit 21 = 0.

  An illegal encoding raises `illegal` with `done`, keeps `wr_en` low, drives a zero result and passes the flags through unchanged.
- R8: In the multiply form, bits 14:10 name the accumulator register and bit 15 selects subtraction. The result is accumulator ± (first × second), truncated to the active width. The flags pass through unchanged.
- R9: A source, second-source or accumulator field of 31 reads as zero, whatever value is on the matching input.
- R10: A destination of 31 keeps `wr_en` low, but flag updates still take effect.
- R11: `done` rises exactly `LAT` cycles after each cycle with `in_valid` high. Results return in issue order, with no gaps for back-to-back issue. `wr_en` is high only together with `done`.
- R12: ADD, SUB, AND, OR and XOR pass the incoming flags through unchanged.
- R13: During and after reset, with nothing issued, `done`, `wr_en`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | DATA_W | Value of the first source register |
| src_b | input | DATA_W | Value of the second source register |
| src_acc | input | DATA_W | Value of the accumulator register (multiply form) |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| done | output | 1 | Result of one instruction is available |
| result | output | DATA_W | Result value, zero when not done or illegal |
| wr_en | output | 1 | Write result to the destination register |
| flags_out | output | 4 | Flags after the instruction {N,Z,C,V} |
| illegal | output | 1 | Completed instruction had an illegal encoding |

## Verification
The hardest cases to reach from the ports combine three things: a rare field pattern, an operand value at a sign or carry boundary, and a shift amount that wraps modulo the width. Examples are SUBS overflow in 32-bit mode when the source carries nonzero upper bits, and ASR of a negative 32-bit value. Random stimulus rarely lands there. The stimulus therefore draws operands from a pool biased toward zero, all-ones and the two sign-boundary values. It chooses register 31 often, and it steers most multiply encodings to the legal field pattern. Directed cases then pin each flag rule and each illegal pattern exactly.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;

  typedef enum logic [1:0] {
    AR_ADD  = 2'd0,
    AR_ADDS = 2'd1,
    AR_SUB  = 2'd2,
    AR_SUBS = 2'd3
  } arith_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_ORR  = 2'd1,
    LG_XOR  = 2'd2,
    LG_ANDS = 2'd3
  } logic_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam logic [4:0] ZERO_REG = 5'd31;

  typedef struct packed {
    logic       wide;
    logic       is_mul;
    logic       is_arith;
    logic [1:0] opc;
    shift_e     sh;
    logic [5:0] amt;
    logic       invert;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
    logic [4:0] ra;
    logic       mul_sub;
    logic       illegal;
    logic       sets_flags;
  } dec_t;

endpackage

// File: rtl/regalu_decode.sv
module regalu_decode
  import regalu_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic unused_class_bits;
  assign unused_class_bits = ^instr[27:25];

  logic arith_bad;
  logic mul_bad;

  always_comb begin
    dec          = '0;
    dec.wide     = instr[31];
    dec.opc      = instr[30:29];
    dec.is_mul   = instr[28];
    dec.is_arith = instr[24];
    dec.sh       = shift_e'(instr[23:22]);
    dec.invert   = instr[21];
    dec.rm       = instr[20:16];
    dec.amt      = instr[15:10];
    dec.mul_sub  = instr[15];
    dec.ra       = instr[14:10];
    dec.rn       = instr[9:5];
    dec.rd       = instr[4:0];

    // arithmetic forms refuse rotate and operand inversion
    arith_bad = instr[24] && ((shift_e'(instr[23:22]) == SH_ROR) || instr[21]);
    // multiply needs a fixed pattern in the fields it shares with arith/logic
    mul_bad   = (instr[30:29] != 2'd0) || !instr[24] ||
                (instr[23:22] != 2'd0) || instr[21];

    dec.illegal    = instr[28] ? mul_bad : arith_bad;
    dec.sets_flags = !instr[28] &&
                     (instr[24] ? instr[29] : (instr[30:29] == 2'd3));
  end

  always_comb begin
    if (dec.is_mul && !dec.illegal)
      p_mul_pattern_r7: assert (dec.opc == 2'd0 && dec.is_arith && !dec.invert && !dec.sets_flags);
  end

endmodule

// File: rtl/regalu_shifter.sv
module regalu_shifter
  import regalu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opnd,
  input  shift_e            sh,
  input  logic [5:0]        amt,
  input  logic              wide,
  output logic [DATA_W-1:0] shifted
);

  localparam int HALF_W = DATA_W / 2;
  localparam int SH_W   = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] shift_full(
    input logic [DATA_W-1:0] x, input shift_e s, input logic [SH_W-1:0] n);
    case (s)
      SH_LSL:  shift_full = x << n;
      SH_LSR:  shift_full = x >> n;
      SH_ASR:  shift_full = $signed(x) >>> n;
      default: shift_full = (x >> n) | (x << (DATA_W - int'(n)));
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] shift_half(
    input logic [HALF_W-1:0] x, input shift_e s, input logic [SH_W-2:0] n);
    case (s)
      SH_LSL:  shift_half = x << n;
      SH_LSR:  shift_half = x >> n;
      SH_ASR:  shift_half = $signed(x) >>> n;
      default: shift_half = (x >> n) | (x << (HALF_W - int'(n)));
    endcase
  endfunction

  logic [SH_W-1:0] amt_eff;

  always_comb begin
    amt_eff = wide ? amt[SH_W-1:0] : {1'b0, amt[SH_W-2:0]};
    if (wide)
      shifted = shift_full(opnd, sh, amt[SH_W-1:0]);
    else
      shifted = {{HALF_W{1'b0}}, shift_half(opnd[HALF_W-1:0], sh, amt[SH_W-2:0])};
  end

  always_comb begin
    if (amt_eff == '0)
      p_zero_amount_identity_r2: assert (shifted[HALF_W-1:0] == opnd[HALF_W-1:0] &&
                                         (!wide || shifted == opnd));
  end

endmodule

// File: rtl/regalu_exec.sv
module regalu_exec
  import regalu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              wide,
  input  logic              is_arith,
  input  logic [1:0]        opc,
  input  logic              invert,
  output logic [DATA_W-1:0] res,
  output nzcv_t             flags_new,
  output logic              carry_out,
  output logic              ovf
);

  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W:0] add_full(
    input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y, input logic cin);
    add_full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  endfunction

  function automatic logic [HALF_W:0] add_half(
    input logic [HALF_W-1:0] x, input logic [HALF_W-1:0] y, input logic cin);
    add_half = {1'b0, x} + {1'b0, y} + {{HALF_W{1'b0}}, cin};
  endfunction

  logic              do_sub;
  logic [DATA_W-1:0] y_arith;
  logic [DATA_W:0]   sum_full;
  logic [HALF_W:0]   sum_half;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] lb;
  logic [DATA_W-1:0] lres;
  logic              res_msb;

  always_comb begin
    do_sub   = opc[1];
    y_arith  = do_sub ? ~b : b;
    sum_full = add_full(a, y_arith, do_sub);
    sum_half = add_half(a[HALF_W-1:0], y_arith[HALF_W-1:0], do_sub);
    if (wide) begin
      sum       = sum_full[DATA_W-1:0];
      carry_out = sum_full[DATA_W];
      ovf       = (a[DATA_W-1] == y_arith[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
    end else begin
      sum       = {{HALF_W{1'b0}}, sum_half[HALF_W-1:0]};
      carry_out = sum_half[HALF_W];
      ovf       = (a[HALF_W-1] == y_arith[HALF_W-1]) && (sum[HALF_W-1] != a[HALF_W-1]);
    end

    lb = invert ? ~b : b;
    if (!wide) lb[DATA_W-1:HALF_W] = '0;
    case (logic_e'(opc))
      LG_AND:  lres = a & lb;
      LG_ORR:  lres = a | lb;
      LG_XOR:  lres = a ^ lb;
      default: lres = a & lb;
    endcase

    res         = is_arith ? sum : lres;
    res_msb     = wide ? res[DATA_W-1] : res[HALF_W-1];
    flags_new.n = res_msb;
    flags_new.z = (res == '0);
    flags_new.c = is_arith && carry_out;
    flags_new.v = is_arith && ovf;
  end

  always_comb begin
    if (is_arith && arith_e'(opc) == AR_SUBS)
      p_subs_carry_r5: assert (carry_out == (wide ? (a >= b) : (a[HALF_W-1:0] >= b[HALF_W-1:0])));
  end

endmodule

// File: rtl/regalu_mac.sv
module regalu_mac #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] acc,
  input  logic              sub,
  input  logic              wide,
  output logic [DATA_W-1:0] res
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] total;

  always_comb begin
    prod  = a * b;
    total = sub ? (acc - prod) : (acc + prod);
    res   = wide ? total : {{HALF_W{1'b0}}, total[HALF_W-1:0]};
  end

  always_comb begin
    if (a == '0 || b == '0)
      p_zero_product_passes_acc_r8: assert (res == (wide ? acc : {{HALF_W{1'b0}}, acc[HALF_W-1:0]}));
  end

endmodule

// File: rtl/regalu_core.sv
module regalu_core
  import regalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_acc,
  input  logic [3:0]        flags_in,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [3:0]        flags_out,
  output logic              illegal
);

  localparam int HALF_W = DATA_W / 2;
  localparam int LAST   = LAT - 1;

  typedef struct packed {
    logic              vld;
    logic              wide;
    logic              mul;
    logic              wr;
    logic              ill;
    nzcv_t             fl_in;
    nzcv_t             fl;
    logic [DATA_W-1:0] res;
  } stage_t;

  function automatic logic [DATA_W-1:0] read_src(
    input logic [DATA_W-1:0] v, input logic [4:0] r, input logic wide);
    if (r == ZERO_REG)
      read_src = '0;
    else if (wide)
      read_src = v;
    else
      read_src = {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  dec_t              dec;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] opacc;
  logic [DATA_W-1:0] opb_shifted;
  logic [DATA_W-1:0] alu_res;
  nzcv_t             alu_flags;
  logic              alu_carry;
  logic              alu_ovf;
  logic [DATA_W-1:0] mac_res;
  stage_t            s0;
  stage_t            stq [LAT];

  regalu_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign opa   = read_src(src_a,   dec.rn, dec.wide);
  assign opb   = read_src(src_b,   dec.rm, dec.wide);
  assign opacc = read_src(src_acc, dec.ra, dec.wide);

  regalu_shifter #(.DATA_W(DATA_W)) u_shift (
    .opnd    (opb),
    .sh      (dec.sh),
    .amt     (dec.amt),
    .wide    (dec.wide),
    .shifted (opb_shifted)
  );

  regalu_exec #(.DATA_W(DATA_W)) u_exec (
    .a         (opa),
    .b         (opb_shifted),
    .wide      (dec.wide),
    .is_arith  (dec.is_arith),
    .opc       (dec.opc),
    .invert    (dec.invert),
    .res       (alu_res),
    .flags_new (alu_flags),
    .carry_out (alu_carry),
    .ovf       (alu_ovf)
  );

  regalu_mac #(.DATA_W(DATA_W)) u_mac (
    .a    (opa),
    .b    (opb),
    .acc  (opacc),
    .sub  (dec.mul_sub),
    .wide (dec.wide),
    .res  (mac_res)
  );

  always_comb begin
    s0       = '0;
    s0.vld   = in_valid;
    s0.wide  = dec.wide;
    s0.mul   = dec.is_mul;
    s0.ill   = dec.illegal;
    s0.wr    = !dec.illegal && (dec.rd != ZERO_REG);
    s0.fl_in = nzcv_t'(flags_in);
    s0.fl    = (dec.illegal || !dec.sets_flags) ? nzcv_t'(flags_in) : alu_flags;
    if (dec.illegal)
      s0.res = '0;
    else if (dec.is_mul)
      s0.res = mac_res;
    else
      s0.res = alu_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) stq[k] <= '0;
    end else begin
      stq[0] <= s0;
      for (int k = 1; k < LAT; k++) stq[k] <= stq[k-1];
    end
  end

  assign done      = stq[LAST].vld;
  assign result    = done ? stq[LAST].res : '0;
  assign wr_en     = done && stq[LAST].wr;
  assign illegal   = done && stq[LAST].ill;
  assign flags_out = stq[LAST].fl;

  p_stage0_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stq[0].vld == $past(in_valid)));

  for (genvar k = 1; k < LAT; k++) begin : g_stage_chk
    p_stage_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (stq[k].vld == $past(stq[k-1].vld)));
  end

  p_write_only_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);

  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (!wr_en && result == '0 && flags_out == stq[LAST].fl_in));

  p_mul_flags_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stq[LAST].mul) |-> (flags_out == stq[LAST].fl_in));

  p_narrow_upper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stq[LAST].wide) |-> (result[DATA_W-1:HALF_W] == '0));

endmodule

// File: tb/regalu_core_test.sv
module regalu_core_test;

  localparam int LAT   = 2;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [63:0] src_acc = '0;
  logic [3:0]  flags_in = '0;
  logic        done;
  logic [63:0] result;
  logic        wr_en;
  logic [3:0]  flags_out;
  logic        illegal;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int wp = 0;
  int rp = 0;

  logic [63:0] e_res [DEPTH];
  bit          e_wr  [DEPTH];
  bit          e_ill [DEPTH];
  logic [3:0]  e_fl  [DEPTH];
  int          e_cyc [DEPTH];
  string       e_tag [DEPTH];

  regalu_core #(.DATA_W(64), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .src_acc(src_acc), .flags_in(flags_in),
    .done(done), .result(result), .wr_en(wr_en), .flags_out(flags_out),
    .illegal(illegal)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  function automatic bit sgn(input logic [63:0] v, input int w);
    return ((v >> (w - 1)) & 64'd1) != 64'd0;
  endfunction

  function automatic void model(input logic [31:0] ins, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] c, input logic [3:0] fin,
      output logic [63:0] r, output bit wr, output bit ill, output logic [3:0] fo);
    bit sf, mul, ar, inv, cf, vf;
    int w, amt;
    logic [63:0] m, av, bv, cv, x, y, p;
    logic [64:0] t;
    logic [1:0] opc, sh;
    sf = ins[31]; mul = ins[28]; ar = ins[24]; inv = ins[21];
    opc = ins[30:29]; sh = ins[23:22];
    w = sf ? 64 : 32;
    m = sf ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    av = (ins[9:5] == 5'd31) ? 64'd0 : (a & m);
    bv = (ins[20:16] == 5'd31) ? 64'd0 : (b & m);
    cv = (ins[14:10] == 5'd31) ? 64'd0 : (c & m);
    amt = int'(ins[15:10]) % w;
    ill = mul ? (opc != 2'd0 || !ar || sh != 2'd0 || inv) : (ar && (sh == 2'd3 || inv));
    fo = fin;
    r = '0;
    if (!ill) begin
      if (mul) begin
        p = (av * bv) & m;
        r = ins[15] ? ((cv - p) & m) : ((cv + p) & m);
      end else begin
        x = bv;
        for (int i = 0; i < amt; i++) begin
          case (sh)
            2'd0: x = (x << 1) & m;
            2'd1: x = x >> 1;
            2'd2: x = (x >> 1) | (x & (64'd1 << (w - 1)));
            default: x = (x >> 1) | ((x & 64'd1) << (w - 1));
          endcase
        end
        if (ar) begin
          if (opc[1]) begin
            r = (av - x) & m;
            cf = av >= x;
            vf = (sgn(av, w) != sgn(x, w)) && (sgn(r, w) != sgn(av, w));
          end else begin
            t = {1'b0, av} + {1'b0, x};
            r = t[63:0] & m;
            cf = sf ? t[64] : t[32];
            vf = (sgn(av, w) == sgn(x, w)) && (sgn(r, w) != sgn(av, w));
          end
          if (opc[0]) fo = {sgn(r, w), r == 64'd0, cf, vf};
        end else begin
          y = inv ? (~x & m) : x;
          case (opc)
            2'd0: r = av & y;
            2'd1: r = av | y;
            2'd2: r = av ^ y;
            default: begin r = av & y; fo = {sgn(r, w), r == 64'd0, 2'b00}; end
          endcase
        end
      end
    end
    wr = !ill && (ins[4:0] != 5'd31);
  endfunction

  function automatic logic [31:0] mk(input bit sf, input logic [1:0] opc, input bit mulf,
      input bit arf, input logic [1:0] sh, input bit inv, input logic [4:0] rm,
      input logic [5:0] imm, input logic [4:0] rn, input logic [4:0] rd);
    return {sf, opc, mulf, 3'b101, arf, sh, inv, rm, imm, rn, rd};
  endfunction

  task automatic send(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] c, input logic [3:0] f, input string tag);
    logic [63:0] r; bit wr, ill; logic [3:0] fo;
    instr = ins; src_a = a; src_b = b; src_acc = c; flags_in = f; in_valid = 1'b1;
    model(ins, a, b, c, f, r, wr, ill, fo);
    e_res[wp] = r; e_wr[wp] = wr; e_ill[wp] = ill; e_fl[wp] = fo;
    e_cyc[wp] = cyc; e_tag[wp] = tag;
    wp++;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    instr = $urandom;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (rp >= wp) begin
        check(1'b0, "R11", "unexpected done", 64'd1, 64'd0);
      end else begin
        check(cyc - e_cyc[rp] == LAT, "R11", "latency", 64'(cyc - e_cyc[rp]), 64'(LAT));
        check(result == e_res[rp], e_tag[rp], "result", result, e_res[rp]);
        check(wr_en == e_wr[rp], e_tag[rp], "wr_en", 64'(wr_en), 64'(e_wr[rp]));
        check(illegal == e_ill[rp], e_tag[rp], "illegal", 64'(illegal), 64'(e_ill[rp]));
        check(flags_out == e_fl[rp], e_tag[rp], "flags", 64'(flags_out), 64'(e_fl[rp]));
        rp++;
      end
    end
  end

  function automatic logic [63:0] pick_val();
    case ($urandom % 7)
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return {$urandom, 32'h8000_0000};
      5: return 64'($urandom % 16);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  function automatic logic [4:0] pick_reg();
    return ($urandom % 8 == 0) ? 5'd31 : 5'($urandom % 31);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired, R11 pending %0d", wp - rp);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240606));
    repeat (3) @(negedge clk);
    // R13 reset state
    check(done == 1'b0 && wr_en == 1'b0, "R13", "done/wr in reset", {done, wr_en}, 64'd0);
    check(illegal == 1'b0 && result == '0, "R13", "illegal/result in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b0 && result == '0, "R13", "idle after reset", result, 64'd0);

    // R4 ADDS wide signed overflow, then carry with zero result
    send(mk(1, 2'd1, 0, 1, 2'd0, 0, 5'd2, 6'd0, 5'd1, 5'd3), 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 4'h0, "R4");
    send(mk(1, 2'd1, 0, 1, 2'd0, 0, 5'd2, 6'd0, 5'd1, 5'd3), '1, 64'd1, 0, 4'h0, "R4");
    // R5 SUBS narrow equal with junk upper bits, a<b, wide overflow
    send(mk(0, 2'd3, 0, 1, 2'd0, 0, 5'd2, 6'd0, 5'd1, 5'd3), 64'hDEAD_0000_0000_0005, 64'h1234_5678_0000_0005, 0, 4'h0, "R5");
    send(mk(0, 2'd3, 0, 1, 2'd0, 0, 5'd2, 6'd0, 5'd1, 5'd3), 64'd3, 64'd7, 0, 4'h0, "R5");
    send(mk(1, 2'd3, 0, 1, 2'd0, 0, 5'd2, 6'd0, 5'd1, 5'd3), 64'h8000_0000_0000_0000, 64'd1, 0, 4'h0, "R5");
    // R3 ASR narrow on negative value, LSR narrow ignores upper bits
    send(mk(0, 2'd0, 0, 1, 2'd2, 0, 5'd2, 6'd4, 5'd31, 5'd3), 0, 64'hFFFF_0000_8000_0000, 0, 4'h0, "R3");
    send(mk(0, 2'd0, 0, 1, 2'd1, 0, 5'd2, 6'd4, 5'd31, 5'd3), 0, 64'hFFFF_FFFF_8000_0000, 0, 4'h0, "R3");
    // R2 ROR logic, LSL by 63, narrow amount 40 wraps to 8
    send(mk(1, 2'd1, 0, 0, 2'd3, 0, 5'd2, 6'd8, 5'd31, 5'd3), 0, 64'h0000_0000_0000_00AB, 0, 4'h0, "R2");
    send(mk(1, 2'd0, 0, 1, 2'd0, 0, 5'd2, 6'd63, 5'd31, 5'd3), 0, 64'd1, 0, 4'h0, "R2");
    send(mk(0, 2'd0, 0, 1, 2'd0, 0, 5'd2, 6'd40, 5'd31, 5'd3), 0, 64'd1, 0, 4'h0, "R2");
    // R7 arithmetic with ROR, with invert; multiply with wrong opcode
    send(mk(1, 2'd1, 0, 1, 2'd3, 0, 5'd2, 6'd1, 5'd1, 5'd3), 64'd5, 64'd6, 0, 4'h6, "R7");
    send(mk(1, 2'd0, 0, 1, 2'd0, 1, 5'd2, 6'd0, 5'd1, 5'd3), 64'd5, 64'd6, 0, 4'h9, "R7");
    send(mk(1, 2'd1, 1, 1, 2'd0, 0, 5'd2, 6'd3, 5'd1, 5'd3), 64'd5, 64'd6, 64'd7, 4'h5, "R7");
    // R6 inverted AND, flag-setting AND clears C and V
    send(mk(1, 2'd0, 0, 0, 2'd0, 1, 5'd2, 6'd0, 5'd1, 5'd3), 64'hFF, 64'h0F, 0, 4'hF, "R6");
    send(mk(1, 2'd3, 0, 0, 2'd0, 0, 5'd2, 6'd0, 5'd1, 5'd3), '1, 64'h8000_0000_0000_0000, 0, 4'h3, "R6");
    // R8 multiply-add wide, multiply-subtract narrow with truncation
    send(mk(1, 2'd0, 1, 1, 2'd0, 0, 5'd2, {1'b0, 5'd4}, 5'd1, 5'd3), 64'd7, 64'd9, 64'd100, 4'hA, "R8");
    send(mk(0, 2'd0, 1, 1, 2'd0, 0, 5'd2, {1'b1, 5'd4}, 5'd1, 5'd3), 64'h1_0001_0000, 64'h3_0000_0002, 64'd1, 4'h5, "R8");
    // R9 zero register as source, second source and accumulator
    send(mk(1, 2'd0, 0, 1, 2'd0, 0, 5'd2, 6'd0, 5'd31, 5'd3), 64'd999, 64'd4, 0, 4'h0, "R9");
    send(mk(1, 2'd1, 0, 0, 2'd0, 0, 5'd31, 6'd0, 5'd1, 5'd3), 64'd16, 64'd999, 0, 4'h0, "R9");
    send(mk(1, 2'd0, 1, 1, 2'd0, 0, 5'd2, {1'b0, 5'd31}, 5'd1, 5'd3), 64'd3, 64'd5, 64'd999, 4'h0, "R9");
    // R10 destination 31 still updates flags; R12 plain op keeps flags
    send(mk(1, 2'd3, 0, 1, 2'd0, 0, 5'd2, 6'd0, 5'd1, 5'd31), 64'd2, 64'd2, 0, 4'h0, "R10");
    send(mk(1, 2'd2, 0, 1, 2'd0, 0, 5'd2, 6'd0, 5'd1, 5'd3), 64'd2, 64'd9, 0, 4'hA, "R12");
    send(mk(1, 2'd2, 0, 0, 2'd0, 0, 5'd2, 6'd0, 5'd1, 5'd3), 64'd2, 64'd9, 0, 4'h5, "R12");
    // R1 ignored class bits 27:25 flipped
    send(mk(1, 2'd0, 0, 1, 2'd0, 0, 5'd2, 6'd0, 5'd1, 5'd3) ^ 32'h0E00_0000, 64'd10, 64'd20, 0, 4'h0, "R1");
    idle();

    // random mix, back to back with occasional gaps
    for (int n = 0; n < 1500; n++) begin
      bit sf, mulf, arf, inv;
      logic [1:0] opc, sh;
      sf = $urandom % 2 == 1;
      mulf = $urandom % 4 == 0;
      arf = $urandom % 2 == 1;
      opc = 2'($urandom);
      sh = 2'($urandom);
      inv = $urandom % 4 == 0;
      if (mulf && ($urandom % 4 != 0)) begin
        opc = 2'd0; arf = 1'b1; sh = 2'd0; inv = 1'b0;
      end
      send(mk(sf, opc, mulf, arf, sh, inv, pick_reg(), 6'($urandom), pick_reg(), pick_reg()),
           pick_val(), pick_val(), pick_val(), 4'($urandom), "R1");
      if ($urandom % 5 == 0) idle();
    end
    idle();
    repeat (LAT + 2) @(negedge clk);
    check(rp == wp, "R11", "completions vs issues", 64'(rp), 64'(wp));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule